// File: doc/BRIEF.md
# Phase-Programmable Receive Sample Capture

This host-side block times the read of a receive data line that carries two values per symbol: a main sample, then an interpolated mid-symbol value. A fast clock runs at 48 ticks per symbol. A symbol-rate reference level, the transmit clock, marks tick 0 with its rising edge. The block produces a receive sync pulse whose start can be moved in steps of 1/48 of a symbol under a 6-bit phase input.

Both capture instants follow the selected phase. The main value is taken halfway between the points where the line switches to it and away from it, at tick (n+13) mod 48. The mid value is taken 24 ticks later, at tick (n+37) mod 48. After a pair taken under one phase is complete, the block raises a one-cycle strobe. The phase is taken up only at a symbol boundary, so a symbol never runs under two phase settings.

Top module: `ps_rx_capture`

## Requirements
- R1: While rst_n is low, rx_sync and sample_valid are low and main_sample and mid_sample are zero.
- R2: Tick 0 is the cycle that follows a cycle in which ref_clk is high after being low in the cycle before. With no further rising edge, the tick count wraps from 47 to 0 by itself. A rising edge in mid-symbol restarts the count at 0.
- R3: rx_sync is high in exactly two cycles of each symbol, at ticks n and (n+1) mod 48, where n is the phase in use.
- R4: A phase_sel value from 48 to 63 gives the same timing as 47.
- R5: phase_sel is taken up only in the last cycle of a symbol, the cycle just before tick 0. A change made in mid-symbol leaves the timing of the rest of that symbol unchanged.
- R6: main_sample takes the rx_data value present in the tick (n+13) mod 48 cycle and holds it until the next main capture.
- R7: mid_sample takes the rx_data value present in the tick (n+37) mod 48 cycle, 24 ticks after the main capture.
- R8: sample_valid is high for one cycle, at tick (n+38) mod 48, and only when the main and mid values it reports were both captured under the same phase. If a phase change falls between a main capture and its mid capture, no strobe is given for that pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, 48 ticks per symbol |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Symbol-rate reference level; its rising edge marks the symbol start |
| phase_sel | input | 6 | Requested sync phase n in 1/48-symbol steps, clamped to 47 |
| rx_data | input | DATA_W (8) | Receive data line |
| rx_sync | output | 1 | Sync pulse, two ticks wide, starting at tick n |
| main_sample | output | DATA_W (8) | Captured main value of the symbol |
| mid_sample | output | DATA_W (8) | Captured interpolated value of the symbol |
| sample_valid | output | 1 | One-cycle strobe when a matched pair is ready |

## Verification
The bench walks the phase values whose capture ticks wrap past the end of the symbol: 10 and 11 move the mid capture across tick 0, 34 and 35 move the main capture across it, and 47 splits the sync pulse over ticks 47 and 0. A design that does not wrap correctly puts its strobe or a sample one symbol off. Phase codes 48 and 63 catch a design that fails to clamp and never places the pulse. A phase change in mid-symbol must leave the current pulse where it is and must drop the stale pair; a design that takes the new phase at once, or that pairs an old main value with a new mid value, gives a wrong pulse or an extra strobe. Running with the reference stopped, and then sending a misplaced reference edge, exposes a counter that either stalls or ignores the realignment.

// File: rtl/ps_cap_pkg.sv
package ps_cap_pkg;

  // Modular addition on the symbol tick ring; k must be below m.
  function automatic int unsigned ring_add(input int unsigned a,
                                           input int unsigned k,
                                           input int unsigned m);
    int unsigned s;
    s = a + k;
    if (s >= m) s = s - m;
    return s;
  endfunction

  // Pairing state of the sampler.
  typedef enum logic {
    PAIR_EMPTY = 1'b0,
    PAIR_HALF  = 1'b1
  } pair_state_e;

endpackage

// File: rtl/ps_tick_gen.sv
module ps_tick_gen #(
  parameter int unsigned TICKS = 48,
  parameter int unsigned TW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_clk,
  input  logic [TW-1:0] phase_req,
  output logic [TW-1:0] tick_q,
  output logic [TW-1:0] phase_q,
  output logic [TW-1:0] tick_d,
  output logic [TW-1:0] phase_d,
  output logic          phase_chg
);

  localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

  logic          ref_prev_q;
  logic          ref_rise;
  logic          at_last;
  logic          boundary;
  logic [TW-1:0] req_clamped;

  always_comb begin
    ref_rise    = ref_clk & ~ref_prev_q;
    at_last     = (tick_q == LAST);
    boundary    = ref_rise | at_last;
    req_clamped = (phase_req > LAST) ? LAST : phase_req;
    tick_d      = boundary ? '0 : tick_q + 1'b1;
    phase_d     = boundary ? req_clamped : phase_q;
    phase_chg   = boundary & (req_clamped != phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_prev_q <= 1'b0;
      tick_q     <= '0;
      phase_q    <= '0;
    end else begin
      ref_prev_q <= ref_clk;
      tick_q     <= tick_d;
      if (boundary) begin
        phase_q <= phase_d;
      end
    end
  end

endmodule

// File: rtl/ps_sync_gen.sv
module ps_sync_gen #(
  parameter int unsigned TICKS    = 48,
  parameter int unsigned TW       = 6,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tick_d,
  input  logic [TW-1:0] phase_d,
  output logic          sync_q
);

  import ps_cap_pkg::*;

  logic [SYNC_LEN-1:0] hit;
  logic                sync_d;

  for (genvar k = 0; k < SYNC_LEN; k++) begin : g_win
    logic [TW-1:0] slot;
    always_comb begin
      slot   = TW'(ring_add(int'(phase_d), k, TICKS));
      hit[k] = (tick_d == slot);
    end
  end

  always_comb begin
    sync_d = |hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
    end
  end

endmodule

// File: rtl/ps_sampler.sv
module ps_sampler #(
  parameter int unsigned TICKS    = 48,
  parameter int unsigned TW       = 6,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MAIN_OFS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     tick_q,
  input  logic [TW-1:0]     phase_q,
  input  logic              phase_chg,
  input  logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] main_q,
  output logic [DATA_W-1:0] mid_q,
  output logic              valid_q
);

  import ps_cap_pkg::*;

  localparam int unsigned MID_OFS = MAIN_OFS + TICKS / 2;

  pair_state_e   st_q, st_d;
  logic [TW-1:0] main_t;
  logic [TW-1:0] mid_t;
  logic          cap_main;
  logic          cap_mid;
  logic          valid_d;

  always_comb begin
    main_t   = TW'(ring_add(int'(phase_q), MAIN_OFS, TICKS));
    mid_t    = TW'(ring_add(int'(phase_q), MID_OFS, TICKS));
    cap_main = (tick_q == main_t);
    cap_mid  = (tick_q == mid_t);
  end

  always_comb begin
    st_d    = st_q;
    valid_d = 1'b0;
    if (cap_main) begin
      st_d = PAIR_HALF;
    end
    if (cap_mid) begin
      valid_d = (st_q == PAIR_HALF);
      st_d    = PAIR_EMPTY;
    end
    if (phase_chg) begin
      st_d = PAIR_EMPTY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PAIR_EMPTY;
      valid_q <= 1'b0;
      main_q  <= '0;
      mid_q   <= '0;
    end else begin
      st_q    <= st_d;
      valid_q <= valid_d;
      if (cap_main) begin
        main_q <= rx_data;
      end
      if (cap_mid) begin
        mid_q <= rx_data;
      end
    end
  end

endmodule

// File: rtl/ps_rx_capture.sv
module ps_rx_capture #(
  parameter int unsigned TICKS    = 48,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SYNC_LEN = 2,
  parameter int unsigned MAIN_OFS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic [5:0]        phase_sel,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_sync,
  output logic [DATA_W-1:0] main_sample,
  output logic [DATA_W-1:0] mid_sample,
  output logic              sample_valid
);

  localparam int unsigned TW = 6;

  logic [TW-1:0] tick_q;
  logic [TW-1:0] phase_q;
  logic [TW-1:0] tick_d;
  logic [TW-1:0] phase_d;
  logic          phase_chg;

  ps_tick_gen #(.TICKS(TICKS), .TW(TW)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_clk   (ref_clk),
    .phase_req (phase_sel),
    .tick_q    (tick_q),
    .phase_q   (phase_q),
    .tick_d    (tick_d),
    .phase_d   (phase_d),
    .phase_chg (phase_chg)
  );

  ps_sync_gen #(.TICKS(TICKS), .TW(TW), .SYNC_LEN(SYNC_LEN)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_d  (tick_d),
    .phase_d (phase_d),
    .sync_q  (rx_sync)
  );

  ps_sampler #(.TICKS(TICKS), .TW(TW), .DATA_W(DATA_W), .MAIN_OFS(MAIN_OFS)) u_samp (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_q    (tick_q),
    .phase_q   (phase_q),
    .phase_chg (phase_chg),
    .rx_data   (rx_data),
    .main_q    (main_sample),
    .mid_q     (mid_sample),
    .valid_q   (sample_valid)
  );

endmodule

// File: rtl/ps_rx_capture_chk.sv
module ps_rx_capture_chk #(
  parameter int unsigned TICKS = 48,
  parameter int unsigned TW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_sync,
  input logic          sample_valid,
  input logic [TW-1:0] tick,
  input logic [TW-1:0] phase
);

  localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

  logic [TW-1:0] phase_next;
  always_comb begin
    phase_next = (phase == LAST) ? '0 : phase + 1'b1;
  end

  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == LAST) |=> (tick == '0)); // R2

  AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_sync) |-> ((tick == phase) || (tick == phase_next))); // R3

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase <= LAST)); // R4

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick != '0) |-> $stable(phase)); // R5

  AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid); // R8

endmodule

bind ps_rx_capture ps_rx_capture_chk #(.TICKS(TICKS), .TW(TW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_sync      (rx_sync),
  .sample_valid (sample_valid),
  .tick         (tick_q),
  .phase        (phase_q)
);

// File: tb/tb_ps_rx_capture.sv
module tb_ps_rx_capture;

  localparam int DW = 8;
  localparam int NV = 10;
  // {phase_sel, expected phase in use}
  localparam logic [11:0] VEC [NV] = '{
    {6'd0,  6'd0},  {6'd1,  6'd1},  {6'd10, 6'd10}, {6'd11, 6'd11},
    {6'd24, 6'd24}, {6'd34, 6'd34}, {6'd35, 6'd35}, {6'd47, 6'd47},
    {6'd48, 6'd47}, {6'd63, 6'd47}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ref_clk;
  logic [5:0]    phase_sel;
  logic [DW-1:0] rx_data;
  logic          rx_sync;
  logic [DW-1:0] main_sample;
  logic [DW-1:0] mid_sample;
  logic          sample_valid;

  int nchk = 0;
  int nerr = 0;
  int bt = 0;
  int cyc = 0;
  bit ref_en = 0;
  bit ref_force = 0;
  bit done = 0;
  logic [DW-1:0] hist [64];

  always #5 clk = ~clk;

  ps_rx_capture dut (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .phase_sel(phase_sel),
    .rx_data(rx_data), .rx_sync(rx_sync), .main_sample(main_sample),
    .mid_sample(mid_sample), .sample_valid(sample_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s at bench tick %0d: actual=%0h expected=%0h", req, bt, act, exp);
    end
  endtask

  // Drive the inputs of the current cycle, then advance the bench tick.
  task automatic drive_cycle();
    logic [DW-1:0] d;
    d = DW'(cyc * 37 + 11);
    hist[cyc & 63] = d;
    rx_data = d;
    ref_clk = ref_force | (ref_en & ((bt == 47) | (bt == 0) | (bt == 1)));
    bt = ref_force ? 0 : (bt + 1) % 48;
    ref_force = 0;
    cyc++;
  endtask

  task automatic run_sym(input int n, input bit on, input string sreq);
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (on) begin
        chk(sreq, rx_sync, (bt == n) || (bt == (n + 1) % 48));
        chk("R8 valid", sample_valid, bt == (n + 38) % 48);
        if (sample_valid && bt == (n + 38) % 48) begin
          chk("R6 main", main_sample, hist[(cyc - 25) & 63]);
          chk("R7 mid", mid_sample, hist[(cyc - 1) & 63]);
        end
      end
      drive_cycle();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ref_clk = 1'b0;
    phase_sel = 6'd0;
    rx_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 sync", rx_sync, 0);
    chk("R1 valid", sample_valid, 0);
    chk("R1 main", main_sample, 0);
    chk("R1 mid", mid_sample, 0);
    rst_n = 1'b1;
    bt = 0;
    drive_cycle();
    ref_en = 1;
    while (bt != 0) begin
      @(negedge clk);
      drive_cycle();
    end

    // Table of phase vectors
    for (int v = 0; v < NV; v++) begin
      int n;
      phase_sel = VEC[v][11:6];
      n = int'(VEC[v][5:0]);
      run_sym(n, 0, "");
      run_sym(n, 0, "");
      run_sym(n, 1, (VEC[v][11:6] > 6'd47) ? "R4 sync" : "R3 sync");
      run_sym(n, 1, (VEC[v][11:6] > 6'd47) ? "R4 sync" : "R3 sync");
    end

    // R5 / R8: mid-symbol phase change
    phase_sel = 6'd20;
    run_sym(20, 0, "");
    run_sym(20, 1, "R3 sync");
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 48; i++) begin
        @(negedge clk);
        if (s == 0 && bt == 5)  chk("R5 old window", rx_sync, 0);
        if (s == 0 && bt == 20) chk("R5 old window kept", rx_sync, 1);
        if (s == 1 && bt == 5)  chk("R5 new window", rx_sync, 1);
        if (s == 1 && bt == 20) chk("R5 old window gone", rx_sync, 0);
        if (s == 1 && bt == 10) chk("R8 split pair dropped", sample_valid, 0);
        if (s == 1 && bt == 43) chk("R8 new pair", sample_valid, 1);
        if (s == 0 && bt == 10) phase_sel = 6'd5;
        drive_cycle();
      end
    end

    // R2: free-running wrap with the reference stopped
    ref_en = 0;
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 48; i++) begin
        @(negedge clk);
        if (bt == 5) chk("R2 free-run sync", rx_sync, 1);
        if (bt == 7) chk("R2 free-run sync off", rx_sync, 0);
        drive_cycle();
      end
    end

    // R2: a misplaced reference edge restarts the count
    while (bt != 20) begin
      @(negedge clk);
      drive_cycle();
    end
    @(negedge clk);
    ref_force = 1;
    drive_cycle();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (bt == 5) chk("R2 realigned sync", rx_sync, 1);
      if (bt == 7) chk("R2 realigned sync off", rx_sync, 0);
      drive_cycle();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule